// File: doc/BRIEF.md
# Boot-Adjusted Cycle Counter

This block is a free-running processor cycle counter with one software write port and one read port. While the count enable is high, the count rises by one on each clock. It wraps from all ones back to zero. Software can load a new count at any time through the write port.

One thing sets the block apart from a plain counter. After a hardware reset, the first software write does not store the data that was written. It stores a start value fixed by a parameter instead. Boot code clears this counter once, just before a memory calibration step that takes real time on physical hardware. An emulated memory needs no calibration, so that time never passes. Because the clear is replaced by the preset, software that reads the counter after boot sees a value in the range that physical hardware would give. Every later write loads its data exactly.

A build parameter can turn the substitution off, which gives an ordinary loadable counter. A one-bit flag records whether the first write has happened. Only a hardware reset clears it.

Top module: `boot_cycle_counter`

## Requirements
- R1: While reset is asserted (rst_n low) and on the first cycle after it, the count reads zero.
- R2: With no write, the count rises by exactly one on each clock where tick_en is high, and holds its value where tick_en is low.
- R3: The count wraps from all ones (32'hFFFF_FFFF at default width) to zero on an enabled clock.
- R4: With USE_PRESET=1, the first write after reset loads BOOT_PRESET, whatever the value on wr_data.
- R5: Every write after the first loads wr_data exactly.
- R6: When a write and tick_en fall in the same cycle, the write decides the next count and no increment is added.
- R7: After any load, the count rises from the loaded value on the next enabled clock.
- R8: A new hardware reset re-arms the substitution, so the next write loads BOOT_PRESET again.
- R9: With USE_PRESET=0, the first write after reset loads wr_data like any other write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Increment enable for this cycle |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | WIDTH | Value software writes |
| rd_data | output | WIDTH | Current count |

## Verification
A software write and an increment can fall in the same clock edge. The bench provokes this by holding tick_en high through both the substituted first write and ordinary later writes. It then checks that the next count equals the preset or the written data, with no extra one added. After each such write it keeps ticking and checks that counting restarts from the loaded value. It also runs a narrow, substitution-free configuration through its full wrap on every cycle.

// File: rtl/boot_cycle_counter_pkg.sv
package boot_cycle_counter_pkg;

   // Decision taken by the write qualifier for the current cycle
   typedef enum logic [1:0] {
      WK_IDLE   = 2'd0,
      WK_PRESET = 2'd1,
      WK_DATA   = 2'd2
   } wr_kind_e;

endpackage

// File: rtl/bcc_wr_qual.sv
module bcc_wr_qual
   import boot_cycle_counter_pkg::*;
#(
   parameter bit USE_PRESET = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   output wr_kind_e wr_kind,
   output logic     first_done
);

   logic done_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      done_q <= 1'b0;
      else if (wr_en)  done_q <= 1'b1;
   end

   assign first_done = done_q;

   generate
      if (USE_PRESET) begin : g_subst
         always_comb begin
            if (!wr_en)       wr_kind = WK_IDLE;
            else if (!done_q) wr_kind = WK_PRESET;
            else              wr_kind = WK_DATA;
         end
      end else begin : g_plain
         always_comb wr_kind = wr_en ? WK_DATA : WK_IDLE;
      end
   endgenerate

   // Once set, the flag stays set until reset
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> done_q); // R8

   AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> done_q); // R4

endmodule

// File: rtl/bcc_count_core.sv
module bcc_count_core
   import boot_cycle_counter_pkg::*;
#(
   parameter int unsigned          WIDTH  = 32,
   parameter logic [WIDTH-1:0]     PRESET = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  wr_kind_e         wr_kind,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] count
);

   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] cnt_q;
   logic [WIDTH-1:0] cnt_inc;

   assign cnt_inc = cnt_q + ONE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         unique case (wr_kind)
            WK_PRESET: cnt_q <= PRESET;
            WK_DATA:   cnt_q <= wr_data;
            default:   if (tick_en) cnt_q <= cnt_inc;
         endcase
      end
   end

   assign count = cnt_q;

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind == WK_IDLE && tick_en) |=> cnt_q == $past(cnt_q) + ONE); // R2

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind == WK_IDLE && !tick_en) |=> $stable(cnt_q)); // R2

   AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind == WK_IDLE && tick_en && &cnt_q) |=> cnt_q == '0); // R3

endmodule

// File: rtl/boot_cycle_counter.sv
module boot_cycle_counter
   import boot_cycle_counter_pkg::*;
#(
   parameter int unsigned      WIDTH       = 32,
   parameter bit               USE_PRESET  = 1'b1,
   parameter logic [WIDTH-1:0] BOOT_PRESET = 32'h0013_6A40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic [WIDTH-1:0] wr_data,
   output logic [WIDTH-1:0] rd_data
);

   generate
      if (WIDTH < 2 || WIDTH > 64) begin : g_bad_width
         $error("boot_cycle_counter: WIDTH must lie in 2..64");
      end
   endgenerate

   wr_kind_e kind;
   logic     first_done;

   bcc_wr_qual #(
      .USE_PRESET (USE_PRESET)
   ) u_qual (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_kind    (kind),
      .first_done (first_done)
   );

   bcc_count_core #(
      .WIDTH  (WIDTH),
      .PRESET (BOOT_PRESET)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_kind (kind),
      .wr_data (wr_data),
      .count   (rd_data)
   );

   generate
      if (USE_PRESET) begin : g_chk_subst
         AST_FIRST_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !first_done) |=> rd_data == BOOT_PRESET); // R4
      end else begin : g_chk_plain
         AST_FIRST_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !first_done) |=> rd_data == $past(wr_data)); // R9
      end
   endgenerate

   AST_LATER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && first_done) |=> rd_data == $past(wr_data)); // R5

   AST_RESET_ZERO: assert property (@(posedge clk)
      (rst_n && $past(!rst_n)) |-> rd_data == '0); // R1

endmodule

// File: tb/boot_cycle_counter_bench.sv
module boot_cycle_counter_bench;

   localparam logic [31:0] PRE   = 32'h0013_6A40;
   localparam logic [7:0]  PRE8  = 8'h5A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0, wr = 1'b0;
   logic [31:0] wdat = '0;
   logic [31:0] rd;
   logic tick8 = 1'b0, wr8 = 1'b0;
   logic [7:0] wdat8 = '0;
   logic [7:0] rd8;

   int n_run = 0, n_fail = 0;
   logic [31:0] exp;
   bit first_seen;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   boot_cycle_counter #(.WIDTH(32), .USE_PRESET(1'b1), .BOOT_PRESET(PRE)) u_boot_cycle_counter (
      .clk(clk), .rst_n(rst_n), .tick_en(tick), .wr_en(wr), .wr_data(wdat), .rd_data(rd));

   boot_cycle_counter #(.WIDTH(8), .USE_PRESET(1'b0), .BOOT_PRESET(PRE8)) u_boot_cycle_counter_plain (
      .clk(clk), .rst_n(rst_n), .tick_en(tick8), .wr_en(wr8), .wr_data(wdat8), .rd_data(rd8));

   task automatic check32(input string req, input logic [31:0] act, input logic [31:0] want);
      n_run++;
      if (act !== want) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, want);
      end
   endtask

   // Drive one cycle from a negedge, sample at the following negedge
   task automatic step(input logic t, input logic w, input logic [31:0] d, input string req);
      tick = t; wr = w; wdat = d;
      @(negedge clk);
      if (w) begin
         exp = first_seen ? d : PRE;
         first_seen = 1'b1;
      end else if (t) begin
         exp = exp + 32'd1;
      end
      check32(req, rd, exp);
      tick = 1'b0; wr = 1'b0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick = 1'b0; wr = 1'b0;
      @(negedge clk);
      exp = '0; first_seen = 1'b0;
      check32("R1 in reset", rd, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check32("R1 after reset", rd, 32'd0);
   endtask

   initial begin
      @(negedge clk);
      do_reset();
      // R2 hold and count
      for (int i = 0; i < 3; i++) step(1'b0, 1'b0, '0, "R2 hold");
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, '0, "R2 count");
      check32("R2 five ticks", rd, 32'd5);
      // R4 + R6: first write with tick high loads preset, no increment
      step(1'b1, 1'b1, 32'h1234_5678, "R4 R6 first write");
      check32("R4 preset value", rd, PRE);
      for (int i = 0; i < 3; i++) step(1'b1, 1'b0, '0, "R7 count from preset");
      check32("R7 preset plus three", rd, PRE + 32'd3);
      // R5 + R6: later write with tick high
      step(1'b1, 1'b1, 32'hDEAD_BEEF, "R5 R6 later write");
      check32("R5 exact data", rd, 32'hDEAD_BEEF);
      step(1'b1, 1'b0, '0, "R7 count from data");
      // R5 write zero with tick low
      step(1'b0, 1'b1, 32'h0, "R5 write zero");
      check32("R5 zero loaded", rd, 32'h0);
      // R3 wrap
      step(1'b0, 1'b1, 32'hFFFF_FFFE, "R5 load near top");
      step(1'b1, 1'b0, '0, "R3 to all ones");
      check32("R3 all ones", rd, 32'hFFFF_FFFF);
      step(1'b1, 1'b0, '0, "R3 wrap");
      check32("R3 wrapped to zero", rd, 32'h0);
      // R8 re-arm
      step(1'b1, 1'b0, '0, "R2 count");
      do_reset();
      step(1'b1, 1'b0, '0, "R2 count after reset");
      step(1'b0, 1'b1, 32'h0, "R8 first write after new reset");
      check32("R8 preset again", rd, PRE);
      step(1'b0, 1'b1, 32'h0000_0077, "R5 second write after new reset");
      check32("R5 second write exact", rd, 32'h77);

      // R9: plain 8-bit instance, first write loads data, full wrap sweep
      tick8 = 1'b0; wr8 = 1'b1; wdat8 = 8'h40;
      @(negedge clk);
      wr8 = 1'b0;
      check32("R9 first write plain", {24'd0, rd8}, 32'h40);
      tick8 = 1'b1;
      for (int i = 1; i <= 260; i++) begin
         @(negedge clk);
         check32("R3 R2 plain sweep", {24'd0, rd8}, 32'((8'h40 + i) % 256));
      end
      tick8 = 1'b1; wr8 = 1'b1; wdat8 = 8'hC3;
      @(negedge clk);
      wr8 = 1'b0; tick8 = 1'b0;
      check32("R6 plain write beats tick", {24'd0, rd8}, 32'hC3);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule